// File: doc/BRIEF.md
# Pulse-and-Verify EPROM Programming Controller

This controller sits on the host side of a byte-wide EPROM and burns a whole array from a source buffer. It walks the addresses in ascending order and shows the buffer the current address. The buffer returns the target byte for that address. Before the first pulse, and again after every pulse, the controller puts the device into read conditions and compares the stored byte with the target. Pulses stop as soon as the byte matches, so a location that already holds its target gets no pulse at all. A location that still differs after a fixed number of pulses stops the run.

Once the last address has matched, the controller drops the raised programming supply and selects the final-verify supply. It then reads the whole array again. The run ends with `done` and exactly one of `pass` or `fail`. On failure, `fail_addr` holds the first address that did not verify.

Supply generation and the memory itself live outside the block. The controller only drives the two supply-select flags and the active-low chip, output and program strobes.

Top module: `eprom_burner`

## Requirements
- R1: Out of reset, and while idle, `ce_n`, `oe_n` and `pgm_n` are high. `sup_prog`, `sup_final`, `done`, `pass` and `fail` are low.
- R2: Each program pulse holds `pgm_n` low for exactly `PULSE_CYC` clock cycles. During the pulse `ce_n` is low, `oe_n` is high, `sup_prog` is high, `dev_wdata` equals `src_data` for the current address, and `dev_addr` does not change.
- R3: A readback samples `dev_rdata` with `ce_n` and `oe_n` low, `pgm_n` high and the same supply selected. The sample is taken only after these conditions have held on the current address for at least `GAP_CYC` cycles, and never less than `GAP_CYC` cycles after a pulse ends.
- R4: A location whose readback already equals its target receives no pulse. This covers an erased byte (all ones) whose target is 0xFF.
- R5: After each pulse, a mismatching location gets another pulse, up to `MAX_PULSES` pulses. If it still mismatches after pulse `MAX_PULSES`, the run stops with `fail` and `done` high, and `fail_addr` set to that address. Addresses above it are never pulsed.
- R6: During programming, `dev_addr` advances by exactly one from 0 to the last address (all ones).
- R7: During the final pass, `sup_final` is high, `sup_prog` is low and no pulses are issued. The two supply flags are never high together. The first mismatch in this pass stops the run with `fail`, `done` and `fail_addr` set to that address.
- R8: A run that verifies every location in both passes ends with `done` and `pass` high and `fail` low. Whenever `done` is high, exactly one of `pass` or `fail` is high.
- R9: A one-cycle `start` pulse begins a run at address 0. It is accepted when idle and after a finished run, whether that run passed or failed, and it clears `done`, `pass` and `fail`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a programming run |
| dev_addr | output | ADDR_W | Address to the device and to the source buffer |
| src_data | input | DATA_W | Target byte for `dev_addr` from the source buffer |
| dev_wdata | output | DATA_W | Data driven to the device during a pulse |
| dev_rdata | input | DATA_W | Data read back from the device |
| ce_n | output | 1 | Chip enable, active low |
| oe_n | output | 1 | Output enable, active low |
| pgm_n | output | 1 | Program strobe, active low |
| sup_prog | output | 1 | Select the raised programming supply |
| sup_final | output | 1 | Select the final-verify supply |
| done | output | 1 | Run finished |
| pass | output | 1 | Run finished with every location verified |
| fail | output | 1 | Run stopped on a location that did not verify |
| fail_addr | output | ADDR_W | Address that caused the failure |

## Verification
The bench uses a device model that returns inverted data until read conditions have held for the settling gap. The model also needs a per-location number of pulses before a byte takes its value. A controller that samples one cycle early therefore shows up as extra pulses on every address. A controller that pulses already-matching 0xFF locations shows up as nonzero pulse counts. A location needing exactly the cap must pass, and one needing one more must fail at that address with no later address touched. An off-by-one on the cap breaks one of those two outcomes. A corrupted byte seen only under the final-verify supply must fail at that address, which a controller that skips or mis-supplies the second pass would miss. Stuck bytes at the first and last address exercise the edge of the address walk.

// File: rtl/eprom_burner.sv
module eprom_burner #(
  parameter int ADDR_W     = 14,
  parameter int DATA_W     = 8,
  parameter int PULSE_CYC  = 10000,
  parameter int GAP_CYC    = 4,
  parameter int MAX_PULSES = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] dev_addr,
  input  logic [DATA_W-1:0] src_data,
  output logic [DATA_W-1:0] dev_wdata,
  input  logic [DATA_W-1:0] dev_rdata,
  output logic              ce_n,
  output logic              oe_n,
  output logic              pgm_n,
  output logic              sup_prog,
  output logic              sup_final,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  localparam int TW = $clog2((PULSE_CYC > GAP_CYC ? PULSE_CYC : GAP_CYC) + 1);
  localparam int CW = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST  = '1;
  localparam logic [TW-1:0]     PLOAD = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0]     GLOAD = TW'(GAP_CYC - 1);
  localparam logic [CW-1:0]     PCAP  = CW'(MAX_PULSES);

  typedef enum logic [2:0] {IDLE, VSET, VCHK, PULSE, FSET, FCHK, FIN} st_t;

  st_t           st;
  logic [TW-1:0] tmr;
  logic [CW-1:0] pcnt;

  wire match = dev_rdata == src_data;

  assign dev_wdata = src_data;
  assign pgm_n     = st != PULSE;
  assign ce_n      = st == IDLE || st == FIN;
  assign oe_n      = ce_n || st == PULSE;
  assign sup_prog  = st == VSET || st == VCHK || st == PULSE;
  assign sup_final = st == FSET || st == FCHK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      tmr       <= '0;
      pcnt      <= '0;
      dev_addr  <= '0;
      fail_addr <= '0;
      done      <= 1'b0;
      pass      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      case (st)
        IDLE, FIN: if (start) begin
          st       <= VSET;
          dev_addr <= '0;
          pcnt     <= '0;
          tmr      <= GLOAD;
          done     <= 1'b0;
          pass     <= 1'b0;
          fail     <= 1'b0;
        end
        VSET: if (tmr == '0) st <= VCHK; else tmr <= tmr - 1'b1;
        VCHK: begin
          if (match) begin
            tmr  <= GLOAD;
            pcnt <= '0;
            if (dev_addr == LAST) begin
              dev_addr <= '0;
              st       <= FSET;
            end else begin
              dev_addr <= dev_addr + 1'b1;
              st       <= VSET;
            end
          end else if (pcnt == PCAP) begin
            fail_addr <= dev_addr;
            fail      <= 1'b1;
            done      <= 1'b1;
            st        <= FIN;
          end else begin
            pcnt <= pcnt + 1'b1;
            tmr  <= PLOAD;
            st   <= PULSE;
          end
        end
        PULSE: if (tmr == '0) begin
          tmr <= GLOAD;
          st  <= VSET;
        end else tmr <= tmr - 1'b1;
        FSET: if (tmr == '0) st <= FCHK; else tmr <= tmr - 1'b1;
        FCHK: begin
          if (!match) begin
            fail_addr <= dev_addr;
            fail      <= 1'b1;
            done      <= 1'b1;
            st        <= FIN;
          end else if (dev_addr == LAST) begin
            pass <= 1'b1;
            done <= 1'b1;
            st   <= FIN;
          end else begin
            dev_addr <= dev_addr + 1'b1;
            tmr      <= GLOAD;
            st       <= FSET;
          end
        end
        default: st <= IDLE;
      endcase
    end
  end

  logic [TW:0] lo_len, hi_len;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_len <= '0;
      hi_len <= '0;
    end else begin
      lo_len <= pgm_n ? '0 : lo_len + 1'b1;
      if (!pgm_n)          hi_len <= '0;
      else if (hi_len != '1) hi_len <= hi_len + 1'b1;
    end
  end

  // R2
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgm_n) |-> lo_len == (TW+1)'(PULSE_CYC));
  // R2
  pulse_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n |-> !ce_n && oe_n && sup_prog && !sup_final);
  // R2
  pulse_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pgm_n |=> pgm_n || $stable(dev_addr));
  // R3
  verify_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == VCHK && pcnt != '0) |-> hi_len >= (TW+1)'(GAP_CYC));
  // R5
  pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PCAP);
  // R7
  supply_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(sup_prog && sup_final));
  // R8
  verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pass != fail));
  // R5
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> ce_n && pgm_n && !sup_prog);
endmodule

// File: tb/eprom_burner_tb.sv
module eprom_burner_tb;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int PC = 4;
  localparam int GC = 2;
  localparam int MX = 5;
  localparam int N  = 1 << AW;

  logic clk = 0;
  logic rst_n = 0;
  logic start = 0;
  logic [AW-1:0] dev_addr, fail_addr;
  logic [DW-1:0] src_data, dev_wdata, dev_rdata;
  logic ce_n, oe_n, pgm_n, sup_prog, sup_final, done, pass, fail;

  logic [DW-1:0] tgt [N];
  logic [DW-1:0] mem [N];
  int need [N];
  int pulses [N];
  int corrupt_addr = -1;
  int settle = 0, lo_len = 0;
  int bad_width = 0, bad_cond = 0, bad_order = 0, bad_final = 0;
  logic prev_pgm = 1, prev_prog = 0, prev_fin = 0;
  logic [AW-1:0] prev_addr = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  assign src_data  = tgt[dev_addr];
  assign dev_rdata = (settle >= GC && !ce_n && !oe_n && pgm_n)
                     ? (mem[dev_addr] ^ ((sup_final && int'(dev_addr) == corrupt_addr) ? 8'h01 : 8'h00))
                     : ~mem[dev_addr];

  eprom_burner #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYC(PC), .GAP_CYC(GC), .MAX_PULSES(MX)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dev_addr(dev_addr), .src_data(src_data),
    .dev_wdata(dev_wdata), .dev_rdata(dev_rdata), .ce_n(ce_n), .oe_n(oe_n), .pgm_n(pgm_n),
    .sup_prog(sup_prog), .sup_final(sup_final), .done(done), .pass(pass), .fail(fail),
    .fail_addr(fail_addr));

  always @(negedge clk) begin
    if (rst_n) begin
      if (!pgm_n) begin
        lo_len++;
        if (oe_n !== 1'b1 || ce_n !== 1'b0 || !sup_prog || dev_wdata !== tgt[dev_addr]) bad_cond++;
        if (sup_final) bad_final++;
      end else if (!prev_pgm) begin
        if (lo_len != PC) bad_width++;
        pulses[dev_addr]++;
        if (pulses[dev_addr] >= need[dev_addr]) mem[dev_addr] = mem[dev_addr] & dev_wdata;
        lo_len = 0;
      end
      if (sup_prog && prev_prog && dev_addr != prev_addr && dev_addr != AW'(prev_addr + 1'b1))
        bad_order++;
      if (!ce_n && !oe_n && pgm_n && dev_addr == prev_addr && sup_final == prev_fin)
        settle++;
      else
        settle = 0;
      prev_pgm  = pgm_n;
      prev_prog = sup_prog;
      prev_fin  = sup_final;
      prev_addr = dev_addr;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int stop_point();
    for (int a = 0; a < N; a++)
      if (tgt[a] != 8'hFF && need[a] > MX) return a;
    return N;
  endfunction

  function automatic int exp_pulses(int a, int stop);
    if (a > stop || tgt[a] == 8'hFF) return 0;
    return need[a] > MX ? MX : need[a];
  endfunction

  task automatic run(string req);
    int wd = 0;
    int stop;
    bit ef;
    int ea;
    for (int a = 0; a < N; a++) begin
      mem[a] = 8'hFF;
      pulses[a] = 0;
    end
    bad_width = 0; bad_cond = 0; bad_order = 0; bad_final = 0;
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
    while (!done && wd < 20000) begin
      @(negedge clk);
      wd++;
    end
    chk({req, " R9 run finished before watchdog"}, int'(done), 1);
    stop = stop_point();
    ef = 1'b0; ea = 0;
    if (stop < N) begin ef = 1'b1; ea = stop; end
    else if (corrupt_addr >= 0) begin ef = 1'b1; ea = corrupt_addr; end
    chk({req, " R8 pass"}, int'(pass), int'(!ef));
    chk({req, " R5/R7 fail"}, int'(fail), int'(ef));
    if (ef) chk({req, " R5/R7 fail_addr"}, int'(fail_addr), ea);
    for (int a = 0; a < N; a++)
      chk($sformatf("%s R4/R5 pulses at %0d", req, a), pulses[a], exp_pulses(a, stop));
    chk({req, " R2 pulse width"}, bad_width, 0);
    chk({req, " R2 pulse conditions"}, bad_cond, 0);
    chk({req, " R6 address order"}, bad_order, 0);
    chk({req, " R7 no pulse in final pass"}, bad_final, 0);
    if (!ef)
      for (int a = 0; a < N; a++)
        chk($sformatf("%s R3 stored byte %0d", req, a), int'(mem[a]), int'(tgt[a]));
  endtask

  task automatic randomize_img(int maxneed);
    for (int a = 0; a < N; a++) begin
      tgt[a]  = ($urandom % 4 == 0) ? 8'hFF : DW'($urandom % 255);
      need[a] = 1 + int'($urandom % maxneed);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int a = 0; a < N; a++) begin
      tgt[a] = 8'hFF; need[a] = 1; mem[a] = 8'hFF; pulses[a] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 ce_n idle", int'(ce_n), 1);
    chk("R1 oe_n idle", int'(oe_n), 1);
    chk("R1 pgm_n idle", int'(pgm_n), 1);
    chk("R1 supplies idle", int'(sup_prog | sup_final), 0);
    chk("R1 status idle", int'({done, pass, fail}), 0);

    run("blank R4");

    randomize_img(3);
    run("random R6");

    need[5] = MX; tgt[5] = 8'h5A;
    run("cap-exact R5");

    need[9] = MX + 1; tgt[9] = 8'h3C;
    run("cap-exceeded R5");

    need[9] = 2;
    run("restart R9");

    corrupt_addr = 12; tgt[12] = 8'h81;
    run("final-corrupt R7");
    corrupt_addr = -1;

    need[N-1] = MX + 3; tgt[N-1] = 8'h00;
    run("stuck-last R5");
    need[N-1] = 1;

    need[0] = MX + 1; tgt[0] = 8'h7E;
    run("stuck-first R5");

    for (int i = 0; i < 6; i++) begin
      randomize_img(MX + 1);
      corrupt_addr = (i == 3) ? int'($urandom % N) : -1;
      run($sformatf("rand%0d R8", i));
    end
    corrupt_addr = -1;

    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R9 watchdog: actual hung expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, errors);
    $finish;
  end
endmodule